// File: doc/BRIEF.md
# Multichannel DMA Control and Interrupt Register File

This block holds the control state for a group of DMA channels: one clock-gate bit per channel, one reset request bit per channel, a sticky command-complete flag per channel with its own interrupt enable, a sticky error flag per channel, and two global burst-enable bits. Software reaches every register through a small memory-mapped port. Each register sits in a 16-byte slot that offers three write views. The plain view replaces the value. The set view turns on the bits written as 1. The clear view turns off the bits written as 1. With the set and clear views, one channel can be changed without a read-modify-write sequence.

The channel engines connect through side-band wires. Each engine receives its gate level and a one-cycle reset pulse. Each engine returns single-cycle completion and error pulses, which the block latches. All enabled completion flags are merged into one interrupt line.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, slot 0x00 reads 0x0000FF00 (every channel gated, burst bits off). Slots 0x10, 0x20 and 0x30 read 0. irq_o, chan_rst_o and burst_o are 0, and gate_o is all ones.
- R2: A write to offset 0x4 of a slot sets each implemented bit that is written as 1. Bits written as 0 keep their value.
- R3: A write to offset 0x8 of a slot clears each implemented bit that is written as 1. Bits written as 0 keep their value.
- R4: A write to offset 0x0 of a slot replaces every implemented bit. Bits that are not implemented always read 0, and any of the three offsets within a slot reads the same value.
- R5: Bit 8+n of slot 0x00 is the gate level of channel n. It drives gate_o[n] (1 means gated) in the cycle after the write that changes it.
- R6: A one-cycle pulse on chan_done_i[n] sets bit n of slot 0x10 from the next cycle on. The bit stays set until software clears it through offset 0x18.
- R7: If a completion pulse and a clear of the same status bit arrive in the same cycle, the bit ends up set.
- R8: irq_o is 1 exactly when some channel n has both status bit n and enable bit 16+n of slot 0x10 set.
- R9: Writing 1 to bit 16+n of slot 0x30, through offset 0x30 or 0x34, drives chan_rst_o[n] high for exactly the next cycle. The bit then clears by itself and reads back as 0.
- R10: A pulse on chan_err_i[n] sets bit n of slot 0x20, and the bit stays set until it is cleared through offset 0x28.
- R11: Writes to offset 0xC of any slot, and writes whose address is not word-aligned, change nothing.
- R12: Bits 1:0 of slot 0x00 are the two burst-enable bits, driven on burst_o[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address: slot in [7:4], write view in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_done_i | input | 8 | Per-channel command-complete pulses |
| chan_err_i | input | 8 | Per-channel error pulses |
| gate_o | output | 8 | Per-channel clock-gate level, 1 = gated |
| chan_rst_o | output | 8 | Per-channel one-cycle reset pulses |
| burst_o | output | 2 | Global burst-enable bits |
| irq_o | output | 1 | Combined command-complete interrupt |

## Verification
A completion pulse from a channel can land in the same cycle as a software clear of that channel's status bit. The bench provokes this by raising chan_done_i[5] during the very cycle that holds a write to offset 0x18 with bit 5 set. It then reads slot 0x10 and expects bit 5 to be set, because the latch has priority over the clear. A second collision, between a channel reset request and the self-clearing of that bit, is checked by following the pulse for two cycles.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NCH      = 8,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int GATE_OFS = 8,
  parameter int IEN_OFS  = 16,
  parameter int RST_OFS  = 16,
  parameter int NBURST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    chan_done_i,
  input  logic [NCH-1:0]    chan_err_i,
  output logic [NCH-1:0]    gate_o,
  output logic [NCH-1:0]    chan_rst_o,
  output logic [NBURST-1:0] burst_o,
  output logic              irq_o
);
  localparam int SW = AW - 4;
  localparam logic [SW-1:0] S_CTL = SW'(0);
  localparam logic [SW-1:0] S_IRQ = SW'(1);
  localparam logic [SW-1:0] S_ERR = SW'(2);
  localparam logic [SW-1:0] S_RST = SW'(3);

  logic [NCH-1:0]    gate_q, stat_q, ien_q, err_q, rst_q;
  logic [NBURST-1:0] burst_q;
  logic [DW-1:0]     w_ctl, w_irq, w_err, w_rst;
  logic [DW-1:0]     n_ctl, n_irq, n_err;
  logic [SW-1:0]     slot;
  logic [1:0]        asel;
  logic              wok, hit_ctl, hit_irq, hit_err, rst_trig;
  logic              unused_bits;

  assign slot     = bus_addr[AW-1:4];
  assign asel     = bus_addr[3:2];
  assign wok      = bus_we && (bus_addr[1:0] == 2'b00) && (asel != 2'd3);
  assign hit_ctl  = wok && (slot == S_CTL);
  assign hit_irq  = wok && (slot == S_IRQ);
  assign hit_err  = wok && (slot == S_ERR);
  assign rst_trig = wok && (slot == S_RST) && (asel != 2'd2);

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] cur,
                                          input logic [DW-1:0] w,
                                          input logic [1:0]    a);
    case (a)
      2'd0:    apply = w;
      2'd1:    apply = cur | w;
      2'd2:    apply = cur & ~w;
      default: apply = cur;
    endcase
  endfunction

  always_comb begin
    w_ctl = '0;
    w_ctl[GATE_OFS +: NCH] = gate_q;
    w_ctl[NBURST-1:0]      = burst_q;
    w_irq = '0;
    w_irq[NCH-1:0]         = stat_q;
    w_irq[IEN_OFS +: NCH]  = ien_q;
    w_err = '0;
    w_err[NCH-1:0]         = err_q;
    w_rst = '0;
    w_rst[RST_OFS +: NCH]  = rst_q;
  end

  assign n_ctl = hit_ctl ? apply(w_ctl, bus_wdata, asel) : w_ctl;
  assign n_irq = hit_irq ? apply(w_irq, bus_wdata, asel) : w_irq;
  assign n_err = hit_err ? apply(w_err, bus_wdata, asel) : w_err;
  assign unused_bits = ^{n_ctl, n_irq, n_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '1;
      burst_q <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      err_q   <= '0;
      rst_q   <= '0;
    end else begin
      gate_q  <= n_ctl[GATE_OFS +: NCH];
      burst_q <= n_ctl[NBURST-1:0];
      stat_q  <= n_irq[NCH-1:0] | chan_done_i;
      ien_q   <= n_irq[IEN_OFS +: NCH];
      err_q   <= n_err[NCH-1:0] | chan_err_i;
      rst_q   <= rst_trig ? bus_wdata[RST_OFS +: NCH] : '0;
    end
  end

  always_comb begin
    case (slot)
      S_CTL:   bus_rdata = w_ctl;
      S_IRQ:   bus_rdata = w_irq;
      S_ERR:   bus_rdata = w_err;
      S_RST:   bus_rdata = w_rst;
      default: bus_rdata = '0;
    endcase
  end

  assign gate_o     = gate_q;
  assign burst_o    = burst_q;
  assign chan_rst_o = rst_q;
  assign irq_o      = |(stat_q & ien_q);

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ctl |=> $stable(gate_o)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_irq |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done_i != '0) |=> ((stat_q & $past(chan_done_i)) == $past(chan_done_i))); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !hit_irq) |=> irq_o); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_rst_o != '0) && !rst_trig) |=> (chan_rst_o == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_err |=> ((err_q & $past(err_q)) == $past(err_q))); // R10
endmodule

// File: tb/test_dma_ctl_regs.sv
module test_dma_ctl_regs;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0, chan_done_i = 0, chan_err_i = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0]  gate_o, chan_rst_o;
  logic [1:0]  burst_o;
  logic        irq_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  dma_ctl_regs i_dma_ctl_regs (.*);

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops expected items and compares them against the outputs
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {31'd0, irq_o};
        2: act = {24'd0, gate_o};
        3: act = {24'd0, chan_rst_o};
        default: act = {30'd0, burst_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d got %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_out(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    expect_out(0, exp, req);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_we = 0; chan_done_i = 0; chan_err_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic pulse(input logic [7:0] done, input logic [7:0] err);
    @(posedge clk); #1;
    chan_done_i = done; chan_err_i = err;
    @(posedge clk); #1;
    chan_done_i = 0; chan_err_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    // R1 reset state
    expect_rd(8'h00, 32'h0000FF00, "R1");
    expect_out(1, 0, "R1"); expect_out(2, 32'hFF, "R1");
    expect_out(3, 0, "R1"); expect_out(4, 0, "R1");
    idle(); expect_rd(8'h10, 0, "R1");
    idle(); expect_rd(8'h20, 0, "R1");
    idle(); expect_rd(8'h30, 0, "R1");
    // R3 clear view, R5 gate output
    wr(8'h08, 32'h00000F00);
    expect_rd(8'h00, 32'h0000F000, "R3"); expect_out(2, 32'hF0, "R5");
    // R2 set view, R12 burst bits
    wr(8'h04, 32'h00000103);
    expect_rd(8'h04, 32'h0000F103, "R2"); expect_out(4, 3, "R12");
    // R4 plain view, unimplemented bits read 0
    wr(8'h00, 32'hFFFFFFFF);
    expect_rd(8'h08, 32'h0000FF03, "R4");
    wr(8'h00, 32'h00005A00);
    expect_rd(8'h00, 32'h00005A00, "R4"); expect_out(2, 32'h5A, "R5");
    expect_out(4, 0, "R12");
    // R11 offset 0xC and misaligned writes ignored
    wr(8'h0C, 32'hFFFFFFFF);
    expect_rd(8'h00, 32'h00005A00, "R11");
    wr(8'h05, 32'h0000FFFF);
    expect_rd(8'h00, 32'h00005A00, "R11");
    // R6 sticky completion
    pulse(8'h08, 0);
    expect_rd(8'h10, 32'h00000008, "R6"); expect_out(1, 0, "R8");
    idle(); idle(); idle();
    expect_rd(8'h10, 32'h00000008, "R6");
    wr(8'h1C, 32'hFFFFFFFF);
    expect_rd(8'h10, 32'h00000008, "R11");
    // R8 interrupt merge
    wr(8'h14, 32'h00080000);
    expect_rd(8'h10, 32'h00080008, "R8"); expect_out(1, 1, "R8");
    wr(8'h18, 32'h00000008);
    expect_rd(8'h10, 32'h00080000, "R6"); expect_out(1, 0, "R8");
    // R7 completion and clear in the same cycle
    pulse(8'h20, 0);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = 8'h18; bus_wdata = 32'h00000020; chan_done_i = 8'h20;
    @(posedge clk); #1;
    bus_we = 0; chan_done_i = 0;
    expect_rd(8'h10, 32'h00080020, "R7"); expect_out(1, 0, "R8");
    wr(8'h14, 32'h00200000);
    expect_out(1, 1, "R8");
    wr(8'h00, 32'h00000000);
    wr(8'h18, 32'h00280020);
    expect_rd(8'h10, 0, "R3"); expect_out(1, 0, "R8");
    // R9 self-clearing channel reset
    wr(8'h34, 32'h00040000);
    expect_out(3, 32'h04, "R9"); expect_rd(8'h30, 32'h00040000, "R9");
    idle();
    expect_out(3, 0, "R9"); expect_rd(8'h30, 0, "R9");
    wr(8'h30, 32'h00810000);
    expect_out(3, 32'h81, "R9");
    idle(); expect_out(3, 0, "R9");
    wr(8'h38, 32'h00FF0000);
    expect_out(3, 0, "R9");
    // R10 error flags
    pulse(0, 8'h40);
    expect_rd(8'h20, 32'h00000040, "R10");
    idle(); idle(); expect_rd(8'h20, 32'h00000040, "R10");
    wr(8'h28, 32'h00000040);
    expect_rd(8'h20, 0, "R10"); expect_out(1, 0, "R10");
    idle(); idle();
    finished = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule